// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a wide synchronous up-counter built from identical 4-bit slices. Each slice has a synchronous parallel load (active low), an asynchronous clear (active low), and two active-high count enables. The parallel enable is shared by every slice. The trickle enable is chained from slice to slice. A slice raises its carry output when its trickle enable is high and it holds all ones. That carry becomes the trickle enable of the next more significant slice, so the slices chain with no extra gating.

The top module takes a full-width load word and returns the full-width count and the final carry. Several such counters can be joined by feeding one counter's carry output into the next counter's carry input. Only cycle-level logical behaviour is modelled.

Top module: `casc_counter`

## Requirements
- R1: Every count bit changes together on the rising clock edge. While the clear input is high, the count does not change between edges.
- R2: While `clr_n` is 0, `count` is 0 at once, without waiting for a clock edge. This holds whatever the clock, load and enable inputs are doing, and it persists across clock edges.
- R3: When `load_n` is 0 at a rising edge, `count` takes `load_val`. This happens whatever the levels of `cnt_en` and `carry_in`.
- R4: When `load_n` is 1 and both `cnt_en` and `carry_in` are 1 at a rising edge, `count` increases by one, modulo 2^(4×N_SLICES).
- R5: When `load_n` is 1 and either `cnt_en` or `carry_in` is 0 at a rising edge, `count` keeps its value.
- R6: `carry_out` is 1 exactly when `carry_in` is 1 and `count` is all ones. `cnt_en` has no influence on it.
- R7: An increment from all ones gives 0, after which `carry_out` is 0.
- R8: Slice k's trickle enable is slice k-1's carry, and slice 0's trickle enable is `carry_in`. A more significant nibble therefore advances on the same edge where the nibbles below it wrap from 0xF to 0x0 (for example 0x0AF becomes 0x0B0).
- R9: `load_val` bits [4k+3:4k] go to slice k, and slice 0 holds the least significant nibble of `count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Shared parallel count enable |
| carry_in | input | 1 | Trickle enable into slice 0 |
| load_val | input | 4×N_SLICES | Parallel load word |
| count | output | 4×N_SLICES | Counter value |
| carry_out | output | 1 | Terminal carry of the top slice |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is load and count. The bench drives `load_n` low with both enables high on the same edge. It expects the load word, not the incremented value.

The second pair is a wrap in the low nibbles and an advance in the upper ones. These fall on the same edge when a value such as 0x0AF is incremented. The bench judges this against its integer reference, which must read 0x0B0 after that edge. It also pulls the clear low between edges and checks that `count` is zero before the next edge arrives.

// File: rtl/ccnt_pkg.sv
package ccnt_pkg;
    localparam int unsigned NIB_W = 4;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2
    } slice_op_e;

    typedef struct packed {
        logic [NIB_W-1:0] cnt;
    } slice_state_t;
endpackage

// File: rtl/ccnt_op_decode.sv
module ccnt_op_decode
    import ccnt_pkg::*;
(
    input  logic      load_n,
    input  logic      par_en,
    input  logic      trk_en,
    output slice_op_e op
);
    // Load outranks both enables; counting needs both enables.
    always_comb begin
        if (!load_n)                op = OP_LOAD;
        else if (par_en && trk_en)  op = OP_INC;
        else                        op = OP_HOLD;
    end
endmodule

// File: rtl/ccnt_slice.sv
module ccnt_slice
    import ccnt_pkg::*;
(
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             par_en,
    input  logic             trk_en,
    input  logic [NIB_W-1:0] din,
    output logic [NIB_W-1:0] q,
    output logic             tc
);
    localparam logic [NIB_W-1:0] ALL_ONES = {NIB_W{1'b1}};

    slice_op_e    op;
    slice_state_t st_d, st_q;

    ccnt_op_decode u_dec (
        .load_n (load_n),
        .par_en (par_en),
        .trk_en (trk_en),
        .op     (op)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD: st_d.cnt = din;
            OP_INC:  st_d.cnt = st_q.cnt + 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q  = st_q.cnt;
    assign tc = trk_en && (st_q.cnt == ALL_ONES);

    // R3: load wins over both enables
    assert_slice_load_R3: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(din));
    // R4: both enables high -> step by one
    assert_slice_inc_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && par_en && trk_en) |=> q == NIB_W'($past(q) + 1'b1));
    // R5: either enable low -> hold
    assert_slice_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(par_en && trk_en)) |=> $stable(q));
    // R6: carry only with trickle enable high
    assert_slice_tc_gate_R6: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> trk_en);
endmodule

// File: rtl/casc_counter.sv
module casc_counter
    import ccnt_pkg::*;
#(
    parameter int unsigned N_SLICES = 3,
    localparam int unsigned W = NIB_W * N_SLICES
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         cnt_en,
    input  logic         carry_in,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         carry_out
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic [N_SLICES:0] trk_chain;
    assign trk_chain[0] = carry_in;

    for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
        ccnt_slice u_slice (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .par_en (cnt_en),
            .trk_en (trk_chain[k]),
            .din    (load_val[k*NIB_W +: NIB_W]),
            .q      (count[k*NIB_W +: NIB_W]),
            .tc     (trk_chain[k+1])
        );
    end

    assign carry_out = trk_chain[N_SLICES];

    // R2: clear forces zero, sampled at every edge while it is held
    assert_clear_zero_R2: assert property (@(posedge clk)
        !clr_n |-> count == '0);
    // R4 / R8: full-width increment across all slices
    assert_wide_inc_R8: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && carry_in) |=> count == W'($past(count) + 1'b1));
    // R6: final carry implies all ones with carry_in high
    assert_carry_full_R6: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (carry_in && count == FULL));
    // R7: a wrap to zero leaves carry low
    assert_wrap_low_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && carry_in && count == FULL) |=> (count == '0 && !carry_out));
endmodule

// File: tb/sim_casc_counter.sv
module sim_casc_counter;
    localparam int N = 3;
    localparam int W = 4 * N;
    localparam logic [W-1:0] MASK = {W{1'b1}};

    logic         clk = 1'b0;
    logic         clr_n, load_n, cnt_en, carry_in;
    logic [W-1:0] load_val;
    logic [W-1:0] count;
    logic         carry_out;

    int total = 0;
    int bad = 0;
    logic [W-1:0] ref_v;
    bit finished = 0;

    always #10 clk = ~clk;

    casc_counter #(.N_SLICES(N)) u0 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_in(carry_in), .load_val(load_val),
        .count(count), .carry_out(carry_out)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_carry(input string tag);
        chk(tag, W'(carry_out), W'(carry_in && ref_v == MASK));
    endtask

    // Drive inputs off the edge, take one edge, update the reference, compare.
    task automatic step(input logic ld_n, input logic pe, input logic ci, input logic [W-1:0] dv);
        load_n = ld_n; cnt_en = pe; carry_in = ci; load_val = dv;
        @(posedge clk); #5;
        if (!ld_n)          ref_v = dv;
        else if (pe && ci)  ref_v = ref_v + 1'b1;
    endtask

    task automatic t_reset;
        clr_n = 1'b0; load_n = 1'b1; cnt_en = 1'b1; carry_in = 1'b1; load_val = '0;
        ref_v = '0;
        repeat (2) @(posedge clk);
        #5;
        chk("R2 reset state", count, '0);
        clr_n = 1'b1;
    endtask

    task automatic t_load;
        step(1'b0, 1'b1, 1'b1, 12'h5A3);
        chk("R3 load with enables high", count, ref_v);
        chk("R9 nibble order slice0 low", W'(count[3:0]), W'(4'h3));
        step(1'b0, 1'b0, 1'b0, 12'h1C7);
        chk("R3 load with enables low", count, ref_v);
    endtask

    task automatic t_count;
        step(1'b1, 1'b1, 1'b1, '0);
        chk("R4 increment", count, ref_v);
        // R1: no change between edges
        load_n = 1'b1; cnt_en = 1'b1; carry_in = 1'b1;
        #8;
        chk("R1 stable between edges", count, ref_v);
        @(posedge clk); #5;
        ref_v = ref_v + 1'b1;
        chk("R1 update at edge", count, ref_v);
    endtask

    task automatic t_hold;
        step(1'b1, 1'b0, 1'b1, 12'hFFF);
        chk("R5 hold cnt_en low", count, ref_v);
        step(1'b1, 1'b1, 1'b0, 12'hFFF);
        chk("R5 hold carry_in low", count, ref_v);
    endtask

    task automatic t_carry;
        step(1'b0, 1'b0, 1'b1, 12'hFFF);
        chk_carry("R6 carry with cnt_en low");
        chk("R6 carry high at full", W'(carry_out), W'(1));
        carry_in = 1'b0; #2;
        chk("R6 carry gated by carry_in", W'(carry_out), W'(0));
        step(1'b1, 1'b1, 1'b1, '0);
        chk("R7 wrap to zero", count, ref_v);
        chk("R7 carry low after wrap", W'(carry_out), W'(0));
        step(1'b0, 1'b0, 1'b0, 12'h00E);
        step(1'b1, 1'b1, 1'b1, '0);
        chk_carry("R6 carry not at 0x00F high nibbles zero");
    endtask

    task automatic t_cascade;
        step(1'b0, 1'b1, 1'b1, 12'h0AF);
        step(1'b1, 1'b1, 1'b1, '0);
        chk("R8 middle nibble advances on wrap", count, ref_v);
        chk("R8 expect 0x0B0", count, 12'h0B0);
        step(1'b0, 1'b1, 1'b1, 12'h3FF);
        step(1'b1, 1'b1, 1'b1, '0);
        chk("R8 two-level ripple free", count, 12'h400);
        step(1'b0, 1'b1, 1'b1, 12'h00F);
        step(1'b1, 1'b1, 1'b0, '0);
        chk("R5 no cascade when carry_in low", count, 12'h00F);
    endtask

    task automatic t_clear_mid;
        step(1'b0, 1'b1, 1'b1, 12'h9B6);
        load_n = 1'b0; load_val = 12'h777; cnt_en = 1'b1; carry_in = 1'b1;
        clr_n = 1'b0;
        #2;
        chk("R2 clear before edge", count, '0);
        @(posedge clk); #5;
        chk("R2 clear held over edge with load", count, '0);
        clr_n = 1'b1;
        ref_v = '0;
        step(1'b1, 1'b1, 1'b1, '0);
        chk("R4 count after clear", count, ref_v);
    endtask

    initial begin
        t_reset();
        t_load();
        t_count();
        t_hold();
        t_carry();
        t_cascade();
        t_clear_mid();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule